// File: doc/BRIEF.md
# Palette RAM Write Port

This block takes colour-RAM writes from the host side of a video controller and commits them into a 64-entry palette memory. The same write path serves three addressing and data-format variants. In the extended mode, entries are word addressed. In the handheld variant, entries are word addressed and keep a 12-bit colour. In the legacy mode, entries are byte addressed and a 6-bit colour is spread into the 9-bit layout before it is stored. The stored words are read back through a registered read port, which feeds the downstream colour lookup.

When a palette write lands while the beam is inside the background span of a displayed line, the panel would briefly show the new colour at the current beam position. The block reports this as a one-cycle bleed request. The request carries the pixel position, the palette index and the colour value. The colour lookup and the frame buffer that consume this request sit outside the block.

Top module: `pal_write_port`

## Requirements
- R1: After reset every palette entry reads as 0x0000 and `bleed_vld_o` is low.
- R2: With `ext_mode_i` high, the palette index is `wr_addr_i[6:1]` (address divided by two, masked to 63). The data word is stored unchanged. `ext_mode_i` takes priority over `handheld_i`.
- R3: With `ext_mode_i` low and `handheld_i` high, the index is `wr_addr_i[5:1]` (address divided by two, masked to 31). The data word is stored unchanged.
- R4: With both mode selects low (legacy), the index is `wr_addr_i[4:0]`. The stored word is `((d<<1)&0x000E) | ((d<<2)&0x00E0) | (d&0x0E00)`, computed from the 16-bit write data `d`.
- R5: `rd_data_o` shows the entry addressed by `rd_addr_i` one clock later. A write is visible to a read address presented in the cycle after the write.
- R6: A bleed request requires `hslot_i >= 6` and `hslot_i < 6 + span`. The span is 171 when `wide_line_i` is high and 141 when it is low.
- R7: A bleed request also requires the line to be displayed. This holds when `vline_i < inactive_start_i + border_bot_i` or when `vline_i > 512 - border_top_i`.
- R8: `bleed_vld_o` is high for exactly the one cycle after the qualifying write edge. `bleed_pos_o = (hslot_i - 6)*2 + 1`, and `bleed_idx_o` equals the written palette index.
- R9: `bleed_color_o` is the written data masked with 0xFFF in the handheld variant outside extended mode. In every other case it is the stored word masked with 0xEEE.
- R10: With `wr_en_i` low, no palette entry changes and no bleed request is raised, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Palette write strobe |
| wr_addr_i | input | 7 | Host write address |
| wr_data_i | input | 16 | Host write data |
| ext_mode_i | input | 1 | Extended mode select |
| handheld_i | input | 1 | Handheld device variant select |
| wide_line_i | input | 1 | Wide (long) line timing select |
| hslot_i | input | 8 | Current horizontal slot |
| vline_i | input | 9 | Current line counter |
| inactive_start_i | input | 9 | First line of vertical blanking |
| border_bot_i | input | 8 | Bottom border height in lines |
| border_top_i | input | 8 | Top border height in lines |
| rd_addr_i | input | 6 | Palette read index |
| rd_data_o | output | 16 | Palette read data, registered |
| bleed_vld_o | output | 1 | One-cycle bleed pixel request |
| bleed_pos_o | output | 9 | Pixel position of the bleed request |
| bleed_idx_o | output | 6 | Palette index of the bleed request |
| bleed_color_o | output | 12 | Colour value of the bleed request |

## Verification
The checker watches several properties on every cycle:
- A bleed request always follows a write strobe and a slot at or past the background start.
- The bleed position is always odd.
- Legacy colours never carry bits outside the 9-bit field.
- The extended-mode bleed index follows the write address.
- The read data holds steady while neither the read index nor the write strobe moves.

Other behaviours need the bench's scenarios to show them:
- The exact repacked values.
- Index aliasing in each mode.
- The horizontal and vertical window edges.
- Whether a write actually reached the right entry.

The bench reads these back through the read port against its own model.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    FMT_LEGACY   = 2'd0,
    FMT_HANDHELD = 2'd1,
    FMT_EXT      = 2'd2
  } pal_fmt_e;

  // spread 2-bit-per-channel legacy colour into the 3-bit-per-channel layout
  function automatic logic [15:0] legacy_repack(input logic [15:0] d);
    return ((d << 1) & 16'h000E) | ((d << 2) & 16'h00E0) | (d & 16'h0E00);
  endfunction

  localparam logic [11:0] COLOR_FIELD_MASK = 12'hEEE;
endpackage

// File: rtl/pal_addr_map.sv
module pal_addr_map
  import pal_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              ext_mode_i,
  input  logic              handheld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output pal_fmt_e          fmt_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [11:0]       color_o
);
  localparam int NARROW_W = 5;

  logic [ADDR_W-1:0] half_addr;
  assign half_addr = addr_i >> 1;

  always_comb begin
    if (ext_mode_i)      fmt_o = FMT_EXT;
    else if (handheld_i) fmt_o = FMT_HANDHELD;
    else                 fmt_o = FMT_LEGACY;
  end

  always_comb begin
    idx_o   = '0;
    wdata_o = data_i;
    color_o = data_i[11:0] & COLOR_FIELD_MASK;
    unique case (fmt_o)
      FMT_EXT: begin
        idx_o = half_addr[IDX_W-1:0];
      end
      FMT_HANDHELD: begin
        idx_o[NARROW_W-1:0] = half_addr[NARROW_W-1:0];
        color_o             = data_i[11:0];
      end
      default: begin
        idx_o[NARROW_W-1:0] = addr_i[NARROW_W-1:0];
        wdata_o             = legacy_repack(data_i);
        color_o             = wdata_o[11:0] & COLOR_FIELD_MASK;
      end
    endcase
  end
endmodule

// File: rtl/pal_bleed_gate.sv
module pal_bleed_gate #(
  parameter int SLOT_W      = 8,
  parameter int LINE_W      = 9,
  parameter int BORDER_W    = 8,
  parameter int BG_START    = 6,
  parameter int SPAN_WIDE   = 171,
  parameter int SPAN_NARROW = 141,
  parameter int POS_W       = SLOT_W + 1
) (
  input  logic                wide_line_i,
  input  logic [SLOT_W-1:0]   hslot_i,
  input  logic [LINE_W-1:0]   vline_i,
  input  logic [LINE_W-1:0]   inactive_start_i,
  input  logic [BORDER_W-1:0] border_bot_i,
  input  logic [BORDER_W-1:0] border_top_i,
  output logic                hit_o,
  output logic [POS_W-1:0]    pos_o
);
  localparam int CMP_W = LINE_W + 2;
  localparam int EXT_W = SLOT_W + 2;
  localparam logic [CMP_W-1:0] WRAP      = CMP_W'(1 << LINE_W);
  localparam logic [EXT_W-1:0] START_V   = EXT_W'(BG_START);
  localparam logic [EXT_W-1:0] END_WIDE  = EXT_W'(BG_START + SPAN_WIDE);
  localparam logic [EXT_W-1:0] END_NARW  = EXT_W'(BG_START + SPAN_NARROW);

  logic [EXT_W-1:0] slot_x, end_slot, rel;
  logic [CMP_W-1:0] line_x, bot_lim, top_lim;
  logic             h_ok, v_ok;

  assign slot_x   = EXT_W'(hslot_i);
  assign end_slot = wide_line_i ? END_WIDE : END_NARW;
  assign h_ok     = (slot_x >= START_V) && (slot_x < end_slot);

  assign line_x  = CMP_W'(vline_i);
  assign bot_lim = CMP_W'(inactive_start_i) + CMP_W'(border_bot_i);
  assign top_lim = WRAP - CMP_W'(border_top_i);
  assign v_ok    = (line_x < bot_lim) || (line_x > top_lim);

  assign hit_o = h_ok && v_ok;
  assign rel   = slot_x - START_V;
  assign pos_o = POS_W'({rel[EXT_W-2:0], 1'b1});
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 entry_q[g] <= '0;
      else if (we_i && (widx_i == IDX_W'(g)))      entry_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= entry_q[ridx_i];
  end
endmodule

// File: rtl/pal_write_port.sv
module pal_write_port
  import pal_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int IDX_W       = 6,
  parameter int DATA_W      = 16,
  parameter int SLOT_W      = 8,
  parameter int LINE_W      = 9,
  parameter int BORDER_W    = 8,
  parameter int BG_START    = 6,
  parameter int SPAN_WIDE   = 171,
  parameter int SPAN_NARROW = 141
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                ext_mode_i,
  input  logic                handheld_i,
  input  logic                wide_line_i,
  input  logic [SLOT_W-1:0]   hslot_i,
  input  logic [LINE_W-1:0]   vline_i,
  input  logic [LINE_W-1:0]   inactive_start_i,
  input  logic [BORDER_W-1:0] border_bot_i,
  input  logic [BORDER_W-1:0] border_top_i,
  input  logic [IDX_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                bleed_vld_o,
  output logic [SLOT_W:0]     bleed_pos_o,
  output logic [IDX_W-1:0]    bleed_idx_o,
  output logic [11:0]         bleed_color_o
);
  localparam int POS_W = SLOT_W + 1;
  localparam int DEPTH = 1 << IDX_W;

  pal_fmt_e          fmt;
  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] wdata;
  logic [11:0]       wcolor;
  logic              hit;
  logic [POS_W-1:0]  pos;

  pal_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_map (
    .ext_mode_i (ext_mode_i),
    .handheld_i (handheld_i),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .fmt_o      (fmt),
    .idx_o      (widx),
    .wdata_o    (wdata),
    .color_o    (wcolor)
  );

  pal_bleed_gate #(
    .SLOT_W(SLOT_W), .LINE_W(LINE_W), .BORDER_W(BORDER_W), .BG_START(BG_START),
    .SPAN_WIDE(SPAN_WIDE), .SPAN_NARROW(SPAN_NARROW), .POS_W(POS_W)
  ) u_gate (
    .wide_line_i      (wide_line_i),
    .hslot_i          (hslot_i),
    .vline_i          (vline_i),
    .inactive_start_i (inactive_start_i),
    .border_bot_i     (border_bot_i),
    .border_top_i     (border_top_i),
    .hit_o            (hit),
    .pos_o            (pos)
  );

  pal_store #(.IDX_W(IDX_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .widx_i  (widx),
    .wdata_i (wdata),
    .ridx_i  (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bleed_vld_o   <= 1'b0;
      bleed_pos_o   <= '0;
      bleed_idx_o   <= '0;
      bleed_color_o <= '0;
    end else begin
      bleed_vld_o <= wr_en_i && hit;
      if (wr_en_i && hit) begin
        bleed_pos_o   <= pos;
        bleed_idx_o   <= widx;
        bleed_color_o <= wcolor;
      end
    end
  end

  logic unused_fmt;
  assign unused_fmt = ^fmt;
endmodule

// File: rtl/pal_write_port_chk.sv
module pal_write_port_chk #(
  parameter int ADDR_W   = 7,
  parameter int IDX_W    = 6,
  parameter int DATA_W   = 16,
  parameter int SLOT_W   = 8,
  parameter int BG_START = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              ext_mode_i,
  input logic              handheld_i,
  input logic [SLOT_W-1:0] hslot_i,
  input logic [IDX_W-1:0]  rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              bleed_vld_o,
  input logic [SLOT_W:0]   bleed_pos_o,
  input logic [IDX_W-1:0]  bleed_idx_o,
  input logic [11:0]       bleed_color_o
);
  assert_bleed_needs_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bleed_vld_o |-> $past(wr_en_i));

  assert_bleed_after_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bleed_vld_o |-> ($past(hslot_i) >= SLOT_W'(BG_START)));

  assert_bleed_pos_odd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bleed_vld_o |-> bleed_pos_o[0]);

  assert_ext_idx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bleed_vld_o && $past(ext_mode_i)) |-> (bleed_idx_o == $past(wr_addr_i[IDX_W:1])));

  assert_legacy_color_field_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bleed_vld_o && !$past(ext_mode_i) && !$past(handheld_i))
      |-> ((bleed_color_o & 12'h111) == 12'h000));

  assert_read_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && !$past(wr_en_i, 2) && ($past(rd_addr_i) == $past(rd_addr_i, 2)))
      |-> $stable(rd_data_o));
endmodule

bind pal_write_port pal_write_port_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .BG_START(BG_START)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .ext_mode_i    (ext_mode_i),
  .handheld_i    (handheld_i),
  .hslot_i       (hslot_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .bleed_vld_o   (bleed_vld_o),
  .bleed_pos_o   (bleed_pos_o),
  .bleed_idx_o   (bleed_idx_o),
  .bleed_color_o (bleed_color_o)
);

// File: tb/tb_pal_write_port.sv
module tb_pal_write_port;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [6:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        ext_mode_i = 1'b0, handheld_i = 1'b0, wide_line_i = 1'b0;
  logic [7:0]  hslot_i = '0;
  logic [8:0]  vline_i = '0;
  logic [8:0]  inactive_start_i = 9'd224;
  logic [7:0]  border_bot_i = 8'd8;
  logic [7:0]  border_top_i = 8'd11;
  logic [5:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        bleed_vld_o;
  logic [8:0]  bleed_pos_o;
  logic [5:0]  bleed_idx_o;
  logic [11:0] bleed_color_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [64];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pal_write_port dut (.*);

  function automatic logic [15:0] repack(input logic [15:0] d);
    return ((d << 1) & 16'h000E) | ((d << 2) & 16'h00E0) | (d & 16'h0E00);
  endfunction

  function automatic logic [5:0] exp_idx(input logic [6:0] a, input logic e, input logic h);
    if (e) return a[6:1];
    if (h) return {1'b0, a[5:1]};
    return {1'b0, a[4:0]};
  endfunction

  function automatic logic [15:0] exp_word(input logic [15:0] d, input logic e, input logic h);
    return (e || h) ? d : repack(d);
  endfunction

  function automatic logic [11:0] exp_color(input logic [15:0] d, input logic e, input logic h);
    if (!e && h) return d[11:0];
    return exp_word(d, e, h) [11:0] & 12'hEEE;
  endfunction

  function automatic bit exp_hit(input int hs, input bit w, input int vl);
    int end_s;
    end_s = 6 + (w ? 171 : 141);
    return (hs >= 6) && (hs < end_s) &&
           ((vl < int'(inactive_start_i) + int'(border_bot_i)) || (vl > 512 - int'(border_top_i)));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d, input bit e, input bit h,
                          input bit w, input int hs, input int vl, input string req);
    bit          hit;
    logic [5:0]  ix;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d; ext_mode_i = e; handheld_i = h;
    wide_line_i = w; hslot_i = 8'(hs); vline_i = 9'(vl);
    hit = exp_hit(hs, w, vl);
    ix  = exp_idx(a, e, h);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(bleed_vld_o == hit, {req, " R6/R7 bleed_vld"}, 32'(bleed_vld_o), 32'(hit));
    if (hit && bleed_vld_o) begin
      chk(bleed_pos_o == 9'((hs - 6) * 2 + 1), {req, " R8 pos"}, 32'(bleed_pos_o), 32'((hs - 6) * 2 + 1));
      chk(bleed_idx_o == ix, {req, " R8 idx"}, 32'(bleed_idx_o), 32'(ix));
      chk(bleed_color_o == exp_color(d, e, h), {req, " R9 color"}, 32'(bleed_color_o), 32'(exp_color(d, e, h)));
    end
    model[ix] = exp_word(d, e, h);
  endtask

  task automatic read_chk(input logic [5:0] ix, input string req);
    @(negedge clk_i);
    rd_addr_i = ix;
    @(negedge clk_i);
    chk(rd_data_o == model[ix], {req, " R5 read"}, 32'(rd_data_o), 32'(model[ix]));
  endtask

  initial begin
    int seed_dummy;
    for (int i = 0; i < 64; i++) model[i] = '0;
    seed_dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(bleed_vld_o == 1'b0, "R1 bleed idle", 32'(bleed_vld_o), 0);
    read_chk(6'd0, "R1");
    read_chk(6'd63, "R1");

    // R2 extended: top address aliases to 63, ext wins over handheld
    do_write(7'h7F, 16'hBEEF, 1, 1, 1, 10, 100, "R2");
    read_chk(6'd63, "R2");
    do_write(7'h02, 16'h0ACE, 1, 0, 0, 5, 100, "R2 slot5");
    read_chk(6'd1, "R2");
    // R3 handheld: address/2 masked to 31
    do_write(7'h7E, 16'h0FFF, 0, 1, 0, 6, 100, "R3");
    read_chk(6'd31, "R3");
    // R4 legacy repack and 5-bit index
    do_write(7'h25, 16'h003F, 0, 0, 0, 145, 231, "R4");
    read_chk(6'd5, "R4");
    chk(model[5] == 16'h00EE, "R4 repack value", 32'(model[5]), 32'h00EE);
    do_write(7'h03, 16'hFE2D, 0, 0, 1, 176, 502, "R4 wide");
    read_chk(6'd3, "R4");
    // R6 end boundaries, R7 line boundaries
    do_write(7'h10, 16'h1234, 1, 0, 0, 146, 100, "R6 narrow end");
    do_write(7'h12, 16'h4321, 1, 0, 1, 177, 100, "R6 wide end");
    do_write(7'h14, 16'h5555, 1, 0, 0, 50, 232, "R7 bottom");
    do_write(7'h16, 16'hAAAA, 1, 0, 0, 50, 501, "R7 top");
    // R10: strobe low does nothing
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_addr_i = 7'h7F; wr_data_i = 16'h0000; ext_mode_i = 1;
    hslot_i = 8'd20; vline_i = 9'd10;
    @(negedge clk_i);
    chk(bleed_vld_o == 1'b0, "R10 no bleed", 32'(bleed_vld_o), 0);
    read_chk(6'd63, "R10");

    for (int n = 0; n < 400; n++) begin
      do_write(7'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               int'($urandom % 256), int'($urandom % 512), "rand");
      read_chk(6'($urandom), "rand");
    end
    for (int i = 0; i < 64; i++) read_chk(6'(i), "sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule